// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a register-mapped timer with a parameterised number of independent channels behind a plain 32-bit single-cycle register port. Each channel holds a 64-bit interval and a 64-bit down-counter, and each is reachable as a low word and a high word. A channel counts at a rate divided from a shared tick enable by a per-channel power-of-two prescaler. When its count runs out, it raises a pending bit. In periodic mode it then reloads its interval and keeps running. In one-shot mode it stops and drops its own enable.

A shared enable mask and a write-one-to-clear pending register combine into a single interrupt line. Clearing a channel's enable does not stop it at once. The channel keeps counting for a fixed number of clock cycles before its count freezes, so software waits a few ticks of another channel before it reprograms a stopped one. Register reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `evtmr_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Address map, with channel n based at 0x20·n. The interrupt-enable mask is at 0x00 and the pending register is at 0x04, with bit n in each belonging to channel n. Control is at base+0x10. Interval low and high are at +0x14 and +0x18. Count low and high are at +0x1C and +0x20. The count words are read-only. Any other offset reads zero and ignores writes.
- R3: Control fields. Bit 0 is run enable. Bit 1 is the reload request, which always reads 0. Bits 6:4 are the prescale select p. Bit 7 selects one-shot when 1 and periodic when 0. All other bits read 0.
- R4: A reload request copies the 64-bit interval into the count at the first clock edge with `tick_en` high, whether the channel is enabled or not. That edge also restarts the prescaler, and it produces no count step.
- R5: While running, a channel takes one count step on every 2^p-th cycle that has `tick_en` high, counted from the last restart. No step occurs without `tick_en`.
- R6: A count step taken with a count of 1 or 0 expires the channel and sets its pending bit at that edge. In periodic mode the same edge loads the interval, so an interval N ≥ 1 gives one expiry every N steps. Otherwise a step subtracts one.
- R7: In one-shot mode an expiry leaves the count at 0 and clears the run enable at the same edge. A control write in that cycle takes precedence.
- R8: A control write that clears a set enable lets the channel keep counting for STOP_DLY more clock edges. After that its count is frozen until a reload.
- R9: Writing 1 to a pending bit clears it. An expiry in the same cycle wins, and writing 0 leaves the bit unchanged.
- R10: `irq` is high exactly when some channel has both its pending bit and its enable-mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer source tick, one clock wide per tick |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is due in the same cycle as the address, so the bench samples it one time unit after driving its inputs at the falling edge. A register write, a reload, a count step, an expiry and the resulting pending bit and `irq` all show at the first rising edge after the stimulus. The frozen count after a disable appears STOP_DLY edges after the write edge. The bench updates its behavioural model at each rising edge from the inputs it held across that edge. It then compares `bus_rdata` and `irq` against the model on every cycle. A few literal checks pin down the one-shot stop, the disable freeze and the high-word reload.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 2 * WORD_W;
    localparam int PSEL_W    = 3;
    localparam int DIV_W     = (1 << PSEL_W) - 1;
    localparam int STOP_W    = 4;
    localparam int CTRL_W    = 8;

    // byte offsets; channel offsets are relative to 0x20*n
    localparam int OFF_IE    = 'h00;
    localparam int OFF_PEND  = 'h04;
    localparam int CH_STRIDE = 'h20;
    localparam int CH_CTRL   = 'h10;
    localparam int CH_IVL_LO = 'h14;
    localparam int CH_IVL_HI = 'h18;
    localparam int CH_CNT_LO = 'h1C;
    localparam int CH_CNT_HI = 'h20;

    // control bit positions
    localparam int CB_RUN    = 0;
    localparam int CB_RLD    = 1;
    localparam int CB_PS_LO  = 4;
    localparam int CB_ONCE   = 7;

    typedef struct packed {
        logic              run_en;
        logic              once;
        logic [PSEL_W-1:0] psel;
        logic              rld;
        logic [STOP_W-1:0] stop;
        logic [CNT_W-1:0]  ivl;
        logic [CNT_W-1:0]  cnt;
    } chan_st_t;
endpackage

// File: rtl/evtmr_prescale.sv
module evtmr_prescale
    import evtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              active,
    input  logic              restart,
    input  logic [PSEL_W-1:0] psel,
    output logic              fire
);
    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] mask;

    always_comb begin
        span  = (DIV_W+1)'(1) << psel;
        mask  = DIV_W'(span - 1'b1);
        fire  = tick_en & active & ((div_q & mask) == mask);
        div_d = div_q;
        if (restart || !active) begin
            div_d = '0;
        end else if (tick_en) begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R5
    no_tick_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |-> !fire);
endmodule

// File: rtl/evtmr_chan.sv
module evtmr_chan
    import evtmr_pkg::*;
#(
    parameter int STOP_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ctrl_we,
    input  logic              ivl_lo_we,
    input  logic              ivl_hi_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0]  ivl,
    output logic [CNT_W-1:0]  cnt,
    output logic              expire
);
    chan_st_t st_d, st_q;
    logic     active, take_rld, step;

    assign active   = st_q.run_en | (st_q.stop != '0);
    assign take_rld = tick_en & st_q.rld;

    evtmr_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .active  (active),
        .restart (take_rld),
        .psel    (st_q.psel),
        .fire    (step)
    );

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (st_q.stop != '0) st_d.stop = st_q.stop - 1'b1;
        if (take_rld) begin
            st_d.cnt = st_q.ivl;
            st_d.rld = 1'b0;
        end else if (step) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                expire = 1'b1;
                if (st_q.once) begin
                    st_d.cnt    = '0;
                    st_d.run_en = 1'b0;
                    st_d.stop   = '0;
                end else begin
                    st_d.cnt = st_q.ivl;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (ctrl_we) begin
            st_d.run_en = wdata[CB_RUN];
            if (st_q.run_en && !wdata[CB_RUN]) st_d.stop = STOP_W'(STOP_DLY);
            if (wdata[CB_RLD]) st_d.rld = 1'b1;
            st_d.psel = wdata[CB_PS_LO +: PSEL_W];
            st_d.once = wdata[CB_ONCE];
        end
        if (ivl_lo_we) st_d.ivl[WORD_W-1:0]     = wdata;
        if (ivl_hi_we) st_d.ivl[CNT_W-1:WORD_W] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[CB_RUN]   = st_q.run_en;
        ctrl_rd[CB_PS_LO +: PSEL_W] = st_q.psel;
        ctrl_rd[CB_ONCE]  = st_q.once;
    end
    assign ivl = st_q.ivl;
    assign cnt = st_q.cnt;

    // R4
    reload_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_rld && !ctrl_we) |=> (!st_q.rld && st_q.cnt == $past(st_q.ivl)));
    // R6
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !st_q.once && !ivl_lo_we && !ivl_hi_we) |=> st_q.cnt == $past(st_q.ivl));
    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && st_q.once && !ctrl_we) |=> (!st_q.run_en && st_q.cnt == '0));
    // R8
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !take_rld) |=> $stable(st_q.cnt));
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
    import evtmr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int STOP_DLY = 2,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic [NUM_CH-1:0] ie;
        logic [NUM_CH-1:0] pend;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [NUM_CH-1:0] exp_vec;
    logic [CTRL_W-1:0] ctrl_a [NUM_CH];
    logic [CNT_W-1:0]  ivl_a  [NUM_CH];
    logic [CNT_W-1:0]  cnt_a  [NUM_CH];
    logic              pend_we;

    assign pend_we = bus_wr && (bus_addr == ADDR_W'(OFF_PEND));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = CH_STRIDE * i;
        evtmr_chan #(.STOP_DLY(STOP_DLY)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .ctrl_we   (bus_wr && bus_addr == ADDR_W'(BASE + CH_CTRL)),
            .ivl_lo_we (bus_wr && bus_addr == ADDR_W'(BASE + CH_IVL_LO)),
            .ivl_hi_we (bus_wr && bus_addr == ADDR_W'(BASE + CH_IVL_HI)),
            .wdata     (bus_wdata),
            .ctrl_rd   (ctrl_a[i]),
            .ivl       (ivl_a[i]),
            .cnt       (cnt_a[i]),
            .expire    (exp_vec[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == ADDR_W'(OFF_IE)) st_d.ie = bus_wdata[NUM_CH-1:0];
        if (pend_we) st_d.pend = st_q.pend & ~bus_wdata[NUM_CH-1:0];
        st_d.pend = st_d.pend | exp_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IE))   bus_rdata[NUM_CH-1:0] = st_q.ie;
        if (bus_addr == ADDR_W'(OFF_PEND)) bus_rdata[NUM_CH-1:0] = st_q.pend;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CH_STRIDE*i + CH_CTRL))   bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_a[i]};
            if (bus_addr == ADDR_W'(CH_STRIDE*i + CH_IVL_LO)) bus_rdata = ivl_a[i][WORD_W-1:0];
            if (bus_addr == ADDR_W'(CH_STRIDE*i + CH_IVL_HI)) bus_rdata = ivl_a[i][CNT_W-1:WORD_W];
            if (bus_addr == ADDR_W'(CH_STRIDE*i + CH_CNT_LO)) bus_rdata = cnt_a[i][WORD_W-1:0];
            if (bus_addr == ADDR_W'(CH_STRIDE*i + CH_CNT_HI)) bus_rdata = cnt_a[i][CNT_W-1:WORD_W];
        end
    end

    assign irq = |(st_q.pend & st_q.ie);

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_we |=> ((st_q.pend & $past(bus_wdata[NUM_CH-1:0]) & ~$past(exp_vec)) == '0));
    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|exp_vec) |=> ((st_q.pend & $past(exp_vec)) == $past(exp_vec)));
    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ie == '0) |-> !irq);
endmodule

// File: tb/evtmr_top_bench.sv
module evtmr_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int SD         = 2;
    localparam int AW         = 8;
    localparam int WD_CYCLES  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // behavioural model state
    bit          m_en  [NCH];
    bit          m_os  [NCH];
    logic [2:0]  m_ps  [NCH];
    bit          m_rp  [NCH];
    int          m_stop[NCH];
    logic [63:0] m_ivl [NCH];
    logic [63:0] m_cnt [NCH];
    int          m_div [NCH];
    logic [NCH-1:0] m_ie, m_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    evtmr_top #(.NUM_CH(NCH), .STOP_DLY(SD), .ADDR_W(AW)) u_evtmr_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int a);
        if (a == 0) return 32'(m_ie);
        if (a == 4) return 32'(m_st);
        for (int c = 0; c < NCH; c++) begin
            if (a == 32*c + 16) return {24'd0, m_os[c], m_ps[c], 3'b000, m_en[c]};
            if (a == 32*c + 20) return m_ivl[c][31:0];
            if (a == 32*c + 24) return m_ivl[c][63:32];
            if (a == 32*c + 28) return m_cnt[c][31:0];
            if (a == 32*c + 32) return m_cnt[c][63:32];
        end
        return 32'd0;
    endfunction

    task automatic m_reset();
        for (int c = 0; c < NCH; c++) begin
            m_en[c] = 0; m_os[c] = 0; m_ps[c] = 0; m_rp[c] = 0; m_stop[c] = 0;
            m_ivl[c] = 0; m_cnt[c] = 0; m_div[c] = 0;
        end
        m_ie = 0; m_st = 0;
    endtask

    task automatic m_update();
        logic [NCH-1:0] ex = '0;
        int a = int'(bus_addr);
        for (int c = 0; c < NCH; c++) begin
            bit run   = m_en[c] || (m_stop[c] > 0);
            int per   = 1 << m_ps[c];
            bit fire  = tick_en && run && ((m_div[c] % per) == per - 1);
            bit rl    = tick_en && m_rp[c];
            bit old_en = m_en[c];
            int nd    = m_div[c];
            if (rl || !run) nd = 0;
            else if (tick_en) nd = (m_div[c] + 1) % 128;
            if (m_stop[c] > 0) m_stop[c]--;
            if (rl) begin
                m_cnt[c] = m_ivl[c]; m_rp[c] = 0;
            end else if (fire) begin
                if (m_cnt[c] <= 1) begin
                    ex[c] = 1'b1;
                    if (m_os[c]) begin m_cnt[c] = 0; m_en[c] = 0; m_stop[c] = 0; end
                    else m_cnt[c] = m_ivl[c];
                end else m_cnt[c] = m_cnt[c] - 1;
            end
            m_div[c] = nd;
            if (bus_wr && a == 32*c + 16) begin
                m_en[c] = bus_wdata[0];
                if (old_en && !bus_wdata[0]) m_stop[c] = SD;
                if (bus_wdata[1]) m_rp[c] = 1;
                m_ps[c] = bus_wdata[6:4];
                m_os[c] = bus_wdata[7];
            end
            if (bus_wr && a == 32*c + 20) m_ivl[c][31:0]  = bus_wdata;
            if (bus_wr && a == 32*c + 24) m_ivl[c][63:32] = bus_wdata;
        end
        if (bus_wr && a == 0) m_ie = bus_wdata[NCH-1:0];
        if (bus_wr && a == 4) m_st = m_st & ~bus_wdata[NCH-1:0];
        m_st = m_st | ex;
    endtask

    // one clock: drive, compare pre-edge state, advance model at edge
    task automatic cyc(input string tag, input bit w, input int a,
                       input logic [31:0] wd, input bit tk);
        bus_wr = w; bus_addr = AW'(a); bus_wdata = wd; tick_en = tk;
        #1;
        chk({tag, " rdata"}, bus_rdata, m_read(a));
        chk({tag, " irq"}, 32'(irq), 32'(|(m_st & m_ie)));
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic run_n(input string tag, input int n, input int a, input int tick_mod);
        for (int i = 0; i < n; i++) cyc(tag, 0, a, 0, (i % tick_mod) != (tick_mod - 1) || tick_mod == 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] held;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        cyc("R1", 0, 'h00, 0, 0);
        cyc("R1", 0, 'h04, 0, 0);
        cyc("R1", 0, 'h10, 0, 0);
        cyc("R1", 0, 'h3C, 0, 0);
        // R3 / R6: periodic channel 0, interval 5, prescale 1
        cyc("R2", 1, 'h14, 5, 0);
        cyc("R2", 1, 'h18, 0, 0);
        cyc("R10", 1, 'h00, 1, 0);
        cyc("R3", 1, 'h10, 'h03, 0);
        cyc("R3", 0, 'h10, 0, 0);
        chk("R3 reload bit reads 0", bus_rdata, 32'h1);
        run_n("R6", 16, 'h1C, 1);
        cyc("R6", 0, 'h04, 0, 0);
        // R9 clear pending
        cyc("R9", 1, 'h04, 1, 0);
        cyc("R9", 0, 'h04, 0, 0);
        chk("R9 pending cleared", bus_rdata, 32'h0);
        run_n("R9", 5, 'h04, 1);
        cyc("R9", 1, 'h04, 1, 1);
        run_n("R9", 4, 'h04, 1);
        // R5 / R7: one-shot channel 1, prescale 4, gapped ticks
        cyc("R5", 1, 'h34, 3, 0);
        cyc("R5", 1, 'h00, 3, 0);
        cyc("R5", 1, 'h30, 'hA3, 0);
        run_n("R5", 30, 'h3C, 3);
        cyc("R7", 0, 'h30, 0, 0);
        chk("R7 one-shot enable cleared", bus_rdata, 32'hA0);
        cyc("R7", 0, 'h3C, 0, 0);
        chk("R7 one-shot count zero", bus_rdata, 32'h0);
        // R8: disable channel 0 while running
        cyc("R8", 1, 'h10, 'h00, 1);
        run_n("R8", SD, 'h1C, 1);
        cyc("R8", 0, 'h1C, 0, 1);
        held = bus_rdata;
        run_n("R8", 6, 'h1C, 1);
        cyc("R8", 0, 'h1C, 0, 1);
        chk("R8 count frozen", bus_rdata, held);
        // R2 undefined offsets and read-only count
        cyc("R2", 1, 'h08, 32'hFFFF_FFFF, 0);
        cyc("R2", 0, 'h08, 0, 0);
        chk("R2 hole reads zero", bus_rdata, 32'h0);
        cyc("R2", 1, 'h1C, 32'h1234_5678, 0);
        cyc("R2", 0, 'h1C, 0, 0);
        chk("R2 count write ignored", bus_rdata, held);
        // R4: reload high word while disabled, no tick then tick
        cyc("R4", 1, 'h18, 1, 0);
        cyc("R4", 1, 'h14, 0, 0);
        cyc("R4", 1, 'h10, 'h02, 0);
        run_n("R4", 3, 'h20, 2);
        cyc("R4", 0, 'h20, 0, 0);
        chk("R4 high word loaded", bus_rdata, 32'h1);
        // R6: all-ones interval free run
        cyc("R6", 1, 'h18, 0, 0);
        cyc("R6", 1, 'h14, 32'hFFFF_FFFF, 0);
        cyc("R6", 1, 'h10, 'h13, 0);
        run_n("R6", 12, 'h1C, 1);
        // R10 masking
        cyc("R10", 1, 'h00, 0, 1);
        run_n("R10", 4, 'h04, 1);
        cyc("R10", 1, 'h00, 2, 1);
        run_n("R10", 3, 'h00, 1);
        done = 1'b1;
        finish_run();
    end
endmodule